// File: doc/BRIEF.md
# Floating-Point Compare, Min/Max and Classify Unit

This block handles the floating-point operations that need no rounding. It takes two operands in IEEE binary interchange format and a 4-bit operation code. It returns one registered result word and an invalid-operation indication. The default format is single precision: 8 exponent bits and 23 fraction bits.

The operations fall into three groups. Minimum and maximum return a floating-point value. Equal, less-than and less-or-equal return an integer 0 or 1. The three sign-injection forms return operand A with a new sign bit. A classify operation returns a one-hot mask that names the category of operand A.

The unit holds no architectural state. The surrounding pipeline accumulates the invalid indication into its own status register. An operation is accepted on any clock edge where `in_valid` is high, and its result appears one cycle later.

Top module: `fpcmp_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result` and `invalid` become 0 after that edge.
- R2: `out_valid` follows `in_valid` one cycle later. When `in_valid` is low, `result` and `invalid` keep their previous values.
- R3: Op 0 (minimum) returns the smaller operand and op 1 (maximum) returns the larger one. For these two ops, -0 (0x80000000) counts as below +0 (0x00000000).
- R4: For minimum and maximum, two NaN inputs give the canonical NaN 0x7FC00000. A single NaN input gives the other operand unchanged.
- R5: Minimum and maximum raise `invalid` when either input is a signaling NaN, even if the result is not NaN. A signaling NaN has an all-ones exponent, a nonzero fraction and fraction bit 22 clear.
- R6: Op 2 (equal), op 3 (less-than) and op 4 (less-or-equal) return 1 or 0 in bit 0 and zeros above it. The result is 0 whenever either operand is NaN, and +0 equals -0 for all three.
- R7: Less-than and less-or-equal raise `invalid` for any NaN input. Equal raises it only for a signaling NaN.
- R8: Ops 5, 6 and 7 return bits 30..0 of A. The sign is B's sign (op 5), its inverse (op 6), or A's sign XOR B's sign (op 7). These ops never raise `invalid` and leave NaN payloads untouched.
- R9: Op 8 returns a one-hot mask of A in bits 9..0, with zeros above, and never raises `invalid`. The bits are: 0 = -inf, 1 = negative normal, 2 = negative subnormal, 3 = -0, 4 = +0, 5 = positive subnormal, 6 = positive normal, 7 = +inf, 8 = signaling NaN, 9 = quiet NaN.
- R10: Op codes 9 to 15 return 0 with `invalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted at this edge |
| op_sel | input | 4 | Operation code |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| out_valid | output | 1 | Result registered from an accepted operation |
| result | output | 32 | Floating-point or integer result |
| invalid | output | 1 | Invalid-operation indication for the result |

## Verification
The bench builds the unit with its default parameters: 8 exponent bits and 23 fraction bits. With that format, the vectors can be written as exact single-precision bit patterns.

These patterns reach every one of the ten classes. They include the smallest subnormal of each sign, both zeros, both infinities, and NaNs whose payloads and sign bits are not canonical. Because the payloads are not canonical, the vectors show whether a NaN operand is passed through unchanged or replaced by the canonical NaN.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [3:0] {
    OP_MIN   = 4'd0,
    OP_MAX   = 4'd1,
    OP_EQ    = 4'd2,
    OP_LT    = 4'd3,
    OP_LE    = 4'd4,
    OP_SGNJ  = 4'd5,
    OP_SGNJN = 4'd6,
    OP_SGNJX = 4'd7,
    OP_CLASS = 4'd8
  } fpcmp_op_e;

  localparam int CLASS_W = 10;

  // bit positions of the class mask; the order is part of the interface
  localparam int CL_NINF  = 0;
  localparam int CL_NNORM = 1;
  localparam int CL_NSUB  = 2;
  localparam int CL_NZERO = 3;
  localparam int CL_PZERO = 4;
  localparam int CL_PSUB  = 5;
  localparam int CL_PNORM = 6;
  localparam int CL_PINF  = 7;
  localparam int CL_SNAN  = 8;
  localparam int CL_QNAN  = 9;

  typedef enum logic [1:0] {
    SG_COPY = 2'd0,
    SG_NEG  = 2'd1,
    SG_XOR  = 2'd2
  } sgnj_mode_e;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] val,
  output logic [CLASS_W-1:0]   mask
);

  localparam int W = 1 + EXP_W + MAN_W;

  logic             sgn;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;
  logic             exp_ones;
  logic             exp_zero;
  logic             frac_zero;
  logic             quiet;

  assign sgn       = val[W-1];
  assign expo      = val[W-2:MAN_W];
  assign frac      = val[MAN_W-1:0];
  assign exp_ones  = &expo;
  assign exp_zero  = ~|expo;
  assign frac_zero = ~|frac;
  assign quiet     = frac[MAN_W-1];

  always_comb begin
    mask = '0;
    if (exp_ones) begin
      if (frac_zero) begin
        mask[sgn ? CL_NINF : CL_PINF] = 1'b1;
      end else begin
        mask[quiet ? CL_QNAN : CL_SNAN] = 1'b1;
      end
    end else if (exp_zero) begin
      if (frac_zero) begin
        mask[sgn ? CL_NZERO : CL_PZERO] = 1'b1;
      end else begin
        mask[sgn ? CL_NSUB : CL_PSUB] = 1'b1;
      end
    end else begin
      mask[sgn ? CL_NNORM : CL_PNORM] = 1'b1;
    end
  end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  input  logic                 a_zero,
  input  logic                 b_zero,
  output logic                 ord_lt,
  output logic                 ord_eq,
  output logic                 mm_lt
);

  localparam int W = 1 + EXP_W + MAN_W;

  logic         sa;
  logic         sb;
  logic [W-2:0] mag_a;
  logic [W-2:0] mag_b;
  logic         mag_lt;
  logic         mag_eq;
  logic         both_zero;

  assign sa        = a[W-1];
  assign sb        = b[W-1];
  assign mag_a     = a[W-2:0];
  assign mag_b     = b[W-2:0];
  assign mag_lt    = mag_a < mag_b;
  assign mag_eq    = mag_a == mag_b;
  assign both_zero = a_zero & b_zero;

  // ordering of non-NaN values; zeros of either sign are equal
  always_comb begin
    if (both_zero) begin
      ord_eq = 1'b1;
      ord_lt = 1'b0;
    end else if (sa != sb) begin
      ord_eq = 1'b0;
      ord_lt = sa;
    end else begin
      ord_eq = mag_eq;
      ord_lt = sa ? (~mag_lt & ~mag_eq) : mag_lt;
    end
  end

  // min/max ordering additionally places -0 below +0
  assign mm_lt = ord_lt | (both_zero & sa & ~sb);

endmodule

// File: rtl/fpcmp_sgnj.sv
module fpcmp_sgnj
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  input  sgnj_mode_e           mode,
  output logic [EXP_W+MAN_W:0] res
);

  localparam int W = 1 + EXP_W + MAN_W;

  logic new_sign;

  always_comb begin
    case (mode)
      SG_COPY: new_sign = b[W-1];
      SG_NEG:  new_sign = ~b[W-1];
      SG_XOR:  new_sign = a[W-1] ^ b[W-1];
      default: new_sign = a[W-1];
    endcase
  end

  assign res = {new_sign, a[W-2:0]};

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [3:0]           op_sel,
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  output logic                 out_valid,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 invalid
);

  localparam int W = 1 + EXP_W + MAN_W;
  localparam int NOPND = 2;
  localparam logic [W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [W-1:0]       opnd [NOPND];
  logic [CLASS_W-1:0] cmask [NOPND];
  logic [NOPND-1:0]   is_nan;
  logic [NOPND-1:0]   is_snan;
  logic [NOPND-1:0]   is_zero;

  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  for (genvar g = 0; g < NOPND; g++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val  (opnd[g]),
      .mask (cmask[g])
    );
    assign is_nan[g]  = cmask[g][CL_SNAN] | cmask[g][CL_QNAN];
    assign is_snan[g] = cmask[g][CL_SNAN];
    assign is_zero[g] = cmask[g][CL_NZERO] | cmask[g][CL_PZERO];
  end

  logic ord_lt;
  logic ord_eq;
  logic mm_lt;

  fpcmp_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ord (
    .a      (op_a),
    .b      (op_b),
    .a_zero (is_zero[0]),
    .b_zero (is_zero[1]),
    .ord_lt (ord_lt),
    .ord_eq (ord_eq),
    .mm_lt  (mm_lt)
  );

  fpcmp_op_e  op;
  sgnj_mode_e sg_mode;
  logic [W-1:0] sg_res;

  assign op = fpcmp_op_e'(op_sel);

  always_comb begin
    case (op)
      OP_SGNJN: sg_mode = SG_NEG;
      OP_SGNJX: sg_mode = SG_XOR;
      default:  sg_mode = SG_COPY;
    endcase
  end

  fpcmp_sgnj #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sgnj (
    .a    (op_a),
    .b    (op_b),
    .mode (sg_mode),
    .res  (sg_res)
  );

  logic         any_nan;
  logic         any_snan;
  logic         both_nan;
  logic [W-1:0] mm_res;
  logic [W-1:0] nxt_res;
  logic         nxt_inv;

  assign any_nan  = |is_nan;
  assign any_snan = |is_snan;
  assign both_nan = &is_nan;

  always_comb begin
    if (both_nan) begin
      mm_res = CANON_NAN;
    end else if (is_nan[0]) begin
      mm_res = op_b;
    end else if (is_nan[1]) begin
      mm_res = op_a;
    end else if (op == OP_MIN) begin
      mm_res = mm_lt ? op_a : op_b;
    end else begin
      mm_res = mm_lt ? op_b : op_a;
    end
  end

  always_comb begin
    nxt_res = '0;
    nxt_inv = 1'b0;
    case (op)
      OP_MIN, OP_MAX: begin
        nxt_res = mm_res;
        nxt_inv = any_snan;
      end
      OP_EQ: begin
        nxt_res[0] = ~any_nan & ord_eq;
        nxt_inv    = any_snan;
      end
      OP_LT: begin
        nxt_res[0] = ~any_nan & ord_lt;
        nxt_inv    = any_nan;
      end
      OP_LE: begin
        nxt_res[0] = ~any_nan & (ord_lt | ord_eq);
        nxt_inv    = any_nan;
      end
      OP_SGNJ, OP_SGNJN, OP_SGNJX: begin
        nxt_res = sg_res;
      end
      OP_CLASS: begin
        nxt_res[CLASS_W-1:0] = cmask[0];
      end
      default: begin
        nxt_res = '0;
        nxt_inv = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= nxt_res;
        invalid <= nxt_inv;
      end
    end
  end

endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [3:0]           op_sel,
  input logic [EXP_W+MAN_W:0] op_a,
  input logic [EXP_W+MAN_W:0] op_b,
  input logic                 out_valid,
  input logic [EXP_W+MAN_W:0] result,
  input logic                 invalid
);

  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] QNAN_REF =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic a_nan;
  logic b_nan;
  assign a_nan = (&op_a[W-2:MAN_W]) && (|op_a[MAN_W-1:0]);
  assign b_nan = (&op_b[W-2:MAN_W]) && (|op_b[MAN_W-1:0]);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(result) && $stable(invalid)));

  // R4
  both_nan_canon_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(op_sel) <= 4'd1
     && $past(a_nan) && $past(b_nan)) |-> (result == QNAN_REF));

  // R6
  cmp_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(op_sel) >= 4'd2 && $past(op_sel) <= 4'd4)
    |-> (result[W-1:1] == '0));

  // R8
  sgnj_body_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(op_sel) >= 4'd5 && $past(op_sel) <= 4'd7)
    |-> (result[W-2:0] == $past(op_a[W-2:0]) && !invalid));

  // R9
  class_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(op_sel) == 4'd8)
    |-> ($countones(result) == 1 && result[W-1:10] == '0 && !invalid));

  // R10
  undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(op_sel) >= 4'd9)
    |-> (result == '0 && !invalid));

endmodule

bind fpcmp_unit fpcmp_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .result    (result),
  .invalid   (invalid)
);

// File: tb/fpcmp_unit_tb.sv
`timescale 1ns/1ps
module fpcmp_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        invalid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fpcmp_unit u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result),
    .invalid   (invalid)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        inv;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VECS [NV] = '{
    // R3 ordering, including signed zeros
    '{4'd3, 4'd0, 32'h3F800000, 32'h40000000, 32'h3F800000, 1'b0},
    '{4'd3, 4'd1, 32'h3F800000, 32'h40000000, 32'h40000000, 1'b0},
    '{4'd3, 4'd0, 32'hBF800000, 32'hC0000000, 32'hC0000000, 1'b0},
    '{4'd3, 4'd1, 32'hBF800000, 32'hC0000000, 32'hBF800000, 1'b0},
    '{4'd3, 4'd0, 32'h00000000, 32'h80000000, 32'h80000000, 1'b0},
    '{4'd3, 4'd1, 32'h80000000, 32'h00000000, 32'h00000000, 1'b0},
    // R4 NaN handling in min/max
    '{4'd4, 4'd0, 32'h7FC00000, 32'h3F800000, 32'h3F800000, 1'b0},
    '{4'd4, 4'd1, 32'h40000000, 32'hFFC00123, 32'h40000000, 1'b0},
    '{4'd4, 4'd0, 32'hFFC00123, 32'h7FC00000, 32'h7FC00000, 1'b0},
    // R5 signaling NaN raises invalid
    '{4'd5, 4'd1, 32'h7F800001, 32'h3F800000, 32'h3F800000, 1'b1},
    '{4'd5, 4'd0, 32'h7F800001, 32'hFF800002, 32'h7FC00000, 1'b1},
    // R6 compare results
    '{4'd6, 4'd2, 32'h3F800000, 32'h3F800000, 32'h00000001, 1'b0},
    '{4'd6, 4'd2, 32'h00000000, 32'h80000000, 32'h00000001, 1'b0},
    '{4'd6, 4'd3, 32'hBF800000, 32'h3F800000, 32'h00000001, 1'b0},
    '{4'd6, 4'd3, 32'h3F800000, 32'h3F800000, 32'h00000000, 1'b0},
    '{4'd6, 4'd4, 32'h3F800000, 32'h3F800000, 32'h00000001, 1'b0},
    '{4'd6, 4'd4, 32'h80000000, 32'h00000000, 32'h00000001, 1'b0},
    '{4'd6, 4'd3, 32'h80000000, 32'h00000000, 32'h00000000, 1'b0},
    '{4'd6, 4'd3, 32'hFF800000, 32'h80000001, 32'h00000001, 1'b0},
    '{4'd6, 4'd4, 32'h40000000, 32'h3F800000, 32'h00000000, 1'b0},
    // R7 quiet versus signaling compares
    '{4'd7, 4'd2, 32'h7FC00000, 32'h3F800000, 32'h00000000, 1'b0},
    '{4'd7, 4'd2, 32'h7F800001, 32'h3F800000, 32'h00000000, 1'b1},
    '{4'd7, 4'd3, 32'h7FC00000, 32'h3F800000, 32'h00000000, 1'b1},
    '{4'd7, 4'd4, 32'h3F800000, 32'h7FC00000, 32'h00000000, 1'b1},
    // R8 sign injection
    '{4'd8, 4'd5, 32'h3F800000, 32'hC0000000, 32'hBF800000, 1'b0},
    '{4'd8, 4'd6, 32'h3F800000, 32'hC0000000, 32'h3F800000, 1'b0},
    '{4'd8, 4'd7, 32'hBF800000, 32'hC0000000, 32'h3F800000, 1'b0},
    '{4'd8, 4'd5, 32'h7F800001, 32'hBF800000, 32'hFF800001, 1'b0},
    '{4'd8, 4'd6, 32'hFFC00123, 32'h00000000, 32'hFFC00123, 1'b0},
    // R9 class mask
    '{4'd9, 4'd8, 32'hFF800000, 32'h0, 32'h00000001, 1'b0},
    '{4'd9, 4'd8, 32'hBF800000, 32'h0, 32'h00000002, 1'b0},
    '{4'd9, 4'd8, 32'h80000001, 32'h0, 32'h00000004, 1'b0},
    '{4'd9, 4'd8, 32'h80000000, 32'h0, 32'h00000008, 1'b0},
    '{4'd9, 4'd8, 32'h00000000, 32'h0, 32'h00000010, 1'b0},
    '{4'd9, 4'd8, 32'h00000001, 32'h0, 32'h00000020, 1'b0},
    '{4'd9, 4'd8, 32'h3F800000, 32'h0, 32'h00000040, 1'b0},
    '{4'd9, 4'd8, 32'h7F800000, 32'h0, 32'h00000080, 1'b0},
    '{4'd9, 4'd8, 32'h7F800001, 32'h0, 32'h00000100, 1'b0},
    '{4'd9, 4'd8, 32'h7FC00000, 32'h0, 32'h00000200, 1'b0},
    // R10 unused op codes
    '{4'd10, 4'd9,  32'h3F800000, 32'h7F800001, 32'h00000000, 1'b0},
    '{4'd10, 4'd15, 32'h7F800001, 32'h7FC00000, 32'h00000000, 1'b0}
  };

  task automatic chk(input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [3:0] op,
                       input logic [31:0] a, input logic [31:0] b);
    in_valid = v;
    op_sel   = op;
    op_a     = a;
    op_b     = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    in_valid = 1'b1;
    op_sel   = 4'd1;
    op_a     = 32'h3F800000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(1, "reset out_valid", {31'b0, out_valid}, 32'd0);
    chk(1, "reset result", result, 32'd0);
    chk(1, "reset invalid", {31'b0, invalid}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(1'b1, VECS[i].op, VECS[i].a, VECS[i].b);
      chk(int'(VECS[i].req), $sformatf("vec %0d result", i), result, VECS[i].res);
      chk(int'(VECS[i].req), $sformatf("vec %0d invalid", i),
          {31'b0, invalid}, {31'b0, VECS[i].inv});
      chk(2, $sformatf("vec %0d out_valid", i), {31'b0, out_valid}, 32'd1);
    end

    // R2 idle cycle holds the last result and invalid flag
    issue(1'b1, 4'd3, 32'h7FC00000, 32'h3F800000);
    issue(1'b0, 4'd8, 32'h3F800000, 32'h3F800000);
    chk(2, "idle out_valid", {31'b0, out_valid}, 32'd0);
    chk(2, "idle result held", result, 32'd0);
    chk(2, "idle invalid held", {31'b0, invalid}, 32'd1);
    issue(1'b1, 4'd0, 32'h3F800000, 32'h40000000);
    chk(2, "resume result", result, 32'h3F800000);

    // R1 reset mid-stream clears outputs
    rst = 1'b1;
    issue(1'b1, 4'd8, 32'h3F800000, 32'h0);
    chk(1, "midrun out_valid", {31'b0, out_valid}, 32'd0);
    chk(1, "midrun result", result, 32'd0);
    rst = 1'b0;
    issue(1'b1, 4'd8, 32'h7F800001, 32'h0);
    chk(9, "after reset class", result, 32'h00000100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule